// File: doc/BRIEF.md
# Serial Link Word Alignment Handshake

This block is the word-level side of a link start-up handshake for a serial channel that carries 34-bit words (32 payload bits plus 2 overhead bits). Each lane runs its own state machine. After reset a lane keeps sending a request pattern to the far end. While the far end answers with alignment words, the lane moves its receive word boundary one bit at a time through a slip pulse to the deserializer, until an alignment word appears intact on the parallel bus. The lane then sends alignment words itself. Each time a run of alignment words comes back, it moves its transmit boundary by one bit. When the far end replies with idle words, the lane is declared synchronized.

The block works only on the parallel word bus. Serializing, clock recovery and scrambling happen outside it. The receive boundary is stepped through `rx_slip`. The transmit boundary is reported as a bit offset on `tx_pos`, which the serializer applies. A registered ready flag rises once every enabled lane is synchronized. If a synchronized lane receives an alignment word or a request pattern, it starts the handshake again from the request phase.

Top module: `wsync_align`

## Requirements
- R1: While reset is held and in the first cycle after its release, every lane sends the request pattern 34'h3F00F0CC3, `link_up`, `rx_slip` and `irq` are low, and both boundary positions are 0.
- R2: After reset or after losing sync, a lane sends the request pattern for at least RST_LEN (default 8) consecutive words before it sends any alignment word.
- R3: During the receive search, each evaluated word that is not the alignment word 34'h2B3C51E97 produces exactly one single-cycle `rx_slip` pulse. An alignment word never produces one. After a slip, the lane waits SLIP_WAIT (default 2) cycles before it evaluates again, so back-to-back slips are SLIP_WAIT+1 cycles apart.
- R4: `rx_pos` counts slips modulo 34. It steps from 33 to 0, and it changes in the same cycle that `rx_slip` rises.
- R5: The lane starts sending alignment words in the cycle after the cycle in which an alignment word was detected at its receive boundary.
- R6: While sending alignment words, `tx_pos` advances by one each time exactly ALIGN_RUN (default 32) consecutive alignment words have been received. Any other word, except idle, restarts the run.
- R7: `tx_pos` changes only while the lane sends alignment words. It steps by one, from 33 to 0 at the top.
- R8: An idle word 34'h14D2AE368 received while sending alignment words raises `link_up` in the next cycle, and the lane then sends idle words.
- R9: A synchronized lane that receives an alignment word or a request pattern drops `link_up` in the next cycle and returns to sending the request pattern. Both boundary positions keep their values.
- R10: While `lane_en` of a lane is low, that lane stays in the request phase: it sends the request pattern, gives no slip and keeps `link_up` low.
- R11: `irq` is registered. In each cycle it equals the value, from the previous cycle, of "at least one lane enabled and every enabled lane has `link_up` high".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_en | input | NUM_LANES | Per-lane enable |
| rx_word | input | NUM_LANES*34 | Received words at the current receive boundary, lane 0 in the low bits |
| rx_slip | output | NUM_LANES | One-cycle request to shift the receive boundary by one bit |
| rx_pos | output | NUM_LANES*6 | Receive boundary offset, modulo 34 |
| tx_word | output | NUM_LANES*34 | Word to transmit |
| tx_pos | output | NUM_LANES*6 | Transmit boundary offset for the serializer, modulo 34 |
| link_up | output | NUM_LANES | Lane synchronized |
| irq | output | 1 | All enabled lanes synchronized |

## Verification
Two events can land in the same cycle: one lane finishing its handshake and another lane being disabled. Both act on the shared ready flag in opposite directions. The bench watches its own far-end model and drops the enable of a stuck lane on the exact cycle that the last other lane receives its first idle word. It then judges `irq` one cycle later against the value it computes from the observed `link_up` and enable vectors. In the same way, the end of a 32-word run and the arrival of an idle word are kept apart: the idle word must end the phase without moving the transmit boundary.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

    typedef enum logic [1:0] {
        ST_REQ   = 2'd0,
        ST_HUNT  = 2'd1,
        ST_TRAIN = 2'd2,
        ST_SYNC  = 2'd3
    } lane_st_e;

endpackage

// File: rtl/wsync_pos.sv
module wsync_pos #(
    parameter int MOD = 34,
    localparam int PW = $clog2(MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] pos
);

    logic [PW-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step) begin
            if (pos_q == PW'(MOD - 1)) begin
                pos_d = '0;
            end else begin
                pos_d = pos_q + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos = pos_q;

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < PW'(MOD)); // R4

endmodule

// File: rtl/wsync_lane.sv
module wsync_lane
    import wsync_pkg::*;
#(
    parameter int            WORD_W    = 34,
    parameter int            RST_LEN   = 8,
    parameter int            SLIP_WAIT = 2,
    parameter int            ALIGN_RUN = 32,
    parameter logic [WORD_W-1:0] REQ_PAT   = 34'h3F00F0CC3,
    parameter logic [WORD_W-1:0] ALIGN_PAT = 34'h2B3C51E97,
    parameter logic [WORD_W-1:0] IDLE_PAT  = 34'h14D2AE368,
    localparam int PW  = $clog2(WORD_W),
    localparam int RCW = $clog2(RST_LEN + 1),
    localparam int SWW = $clog2(SLIP_WAIT + 1),
    localparam int RUW = $clog2(ALIGN_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_en,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_word,
    output logic              rx_slip,
    output logic              link_up,
    output logic [PW-1:0]     rx_pos,
    output logic [PW-1:0]     tx_pos
);

    typedef struct packed {
        lane_st_e       st;
        logic [RCW-1:0] req_cnt;
        logic [SWW-1:0] settle;
        logic [RUW-1:0] run;
        logic           slip;
    } lane_reg_t;

    lane_reg_t r_d, r_q;
    logic      tx_adv;
    logic      is_align, is_idle, is_req;

    assign is_align = (rx_word == ALIGN_PAT);
    assign is_idle  = (rx_word == IDLE_PAT);
    assign is_req   = (rx_word == REQ_PAT);

    always_comb begin
        r_d      = r_q;
        r_d.slip = 1'b0;
        tx_adv   = 1'b0;
        if (!lane_en) begin
            r_d.st      = ST_REQ;
            r_d.req_cnt = '0;
            r_d.settle  = '0;
            r_d.run     = '0;
        end else begin
            case (r_q.st)
                ST_REQ: begin
                    if (r_q.req_cnt == RCW'(RST_LEN - 1)) begin
                        r_d.st     = ST_HUNT;
                        r_d.settle = '0;
                    end else begin
                        r_d.req_cnt = r_q.req_cnt + RCW'(1);
                    end
                end
                ST_HUNT: begin
                    if (r_q.settle != '0) begin
                        r_d.settle = r_q.settle - SWW'(1);
                    end else if (is_align) begin
                        r_d.st  = ST_TRAIN;
                        r_d.run = '0;
                    end else begin
                        r_d.slip   = 1'b1;
                        r_d.settle = SWW'(SLIP_WAIT);
                    end
                end
                ST_TRAIN: begin
                    if (is_idle) begin
                        r_d.st = ST_SYNC;
                    end else if (is_align) begin
                        if (r_q.run == RUW'(ALIGN_RUN - 1)) begin
                            r_d.run = '0;
                            tx_adv  = 1'b1;
                        end else begin
                            r_d.run = r_q.run + RUW'(1);
                        end
                    end else begin
                        r_d.run = '0;
                    end
                end
                ST_SYNC: begin
                    if (is_align || is_req) begin
                        r_d.st      = ST_REQ;
                        r_d.req_cnt = '0;
                    end
                end
                default: r_d.st = ST_REQ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_REQ, req_cnt: '0, settle: '0, run: '0, slip: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            ST_TRAIN: tx_word = ALIGN_PAT;
            ST_SYNC:  tx_word = IDLE_PAT;
            default:  tx_word = REQ_PAT;
        endcase
    end

    assign rx_slip = r_q.slip;
    assign link_up = (r_q.st == ST_SYNC);

    wsync_pos #(.MOD(WORD_W)) u_rx_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (r_d.slip),
        .pos   (rx_pos)
    );

    wsync_pos #(.MOD(WORD_W)) u_tx_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tx_adv),
        .pos   (tx_pos)
    );

    AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |=> !rx_slip); // R3
    AST_SLIP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |-> $past(rx_word != ALIGN_PAT)); // R3
    AST_RX_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |-> (rx_pos == (($past(rx_pos) == PW'(WORD_W - 1)) ? '0 : $past(rx_pos) + PW'(1)))); // R4
    AST_TX_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_TRAIN) |=> $stable(tx_pos)); // R7
    AST_SYNC_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(rx_word == IDLE_PAT)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_en |=> (!link_up && !rx_slip)); // R10

endmodule

// File: rtl/wsync_ready.sv
module wsync_ready #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [NUM_LANES-1:0] link_up,
    output logic                 irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = (|lane_en) && (&(link_up | ~lane_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lane_en & ~link_up)) |=> !irq); // R11
    AST_IRQ_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en == '0) |=> !irq); // R11

endmodule

// File: rtl/wsync_align.sv
module wsync_align
    import wsync_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WORD_W    = 34,
    parameter int RST_LEN   = 8,
    parameter int SLIP_WAIT = 2,
    parameter int ALIGN_RUN = 32,
    parameter logic [WORD_W-1:0] REQ_PAT   = 34'h3F00F0CC3,
    parameter logic [WORD_W-1:0] ALIGN_PAT = 34'h2B3C51E97,
    parameter logic [WORD_W-1:0] IDLE_PAT  = 34'h14D2AE368
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_LANES-1:0]                 lane_en,
    input  logic [NUM_LANES*WORD_W-1:0]          rx_word,
    output logic [NUM_LANES-1:0]                 rx_slip,
    output logic [NUM_LANES*$clog2(WORD_W)-1:0]  rx_pos,
    output logic [NUM_LANES*WORD_W-1:0]          tx_word,
    output logic [NUM_LANES*$clog2(WORD_W)-1:0]  tx_pos,
    output logic [NUM_LANES-1:0]                 link_up,
    output logic                                 irq
);

    localparam int PW = $clog2(WORD_W);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wsync_lane #(
            .WORD_W    (WORD_W),
            .RST_LEN   (RST_LEN),
            .SLIP_WAIT (SLIP_WAIT),
            .ALIGN_RUN (ALIGN_RUN),
            .REQ_PAT   (REQ_PAT),
            .ALIGN_PAT (ALIGN_PAT),
            .IDLE_PAT  (IDLE_PAT)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_en (lane_en[g]),
            .rx_word (rx_word[g*WORD_W +: WORD_W]),
            .tx_word (tx_word[g*WORD_W +: WORD_W]),
            .rx_slip (rx_slip[g]),
            .link_up (link_up[g]),
            .rx_pos  (rx_pos[g*PW +: PW]),
            .tx_pos  (tx_pos[g*PW +: PW])
        );
    end

    wsync_ready #(.NUM_LANES(NUM_LANES)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_en (lane_en),
        .link_up (link_up),
        .irq     (irq)
    );

endmodule

// File: tb/wsync_align_tb.sv
module wsync_align_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 4;
    localparam int W    = 34;
    localparam int PW   = 6;
    localparam int RUN  = 32;
    localparam int RLEN = 8;
    localparam int SW   = 2;
    localparam int WDOG = 150000;
    localparam logic [W-1:0] P_REQ   = 34'h3F00F0CC3;
    localparam logic [W-1:0] P_ALIGN = 34'h2B3C51E97;
    localparam logic [W-1:0] P_IDLE  = 34'h14D2AE368;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NL-1:0]     lane_en;
    logic [NL*W-1:0]   rx_word;
    logic [NL-1:0]     rx_slip;
    logic [NL*PW-1:0]  rx_pos;
    logic [NL*W-1:0]   tx_word;
    logic [NL*PW-1:0]  tx_pos;
    logic [NL-1:0]     link_up;
    logic              irq;

    wsync_align u_dut (
        .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .rx_word(rx_word),
        .rx_slip(rx_slip), .rx_pos(rx_pos), .tx_word(tx_word), .tx_pos(tx_pos),
        .link_up(link_up), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit mon_on = 0;

    int true_off[NL], tgt[NL], rx_gate[NL], tx_gate[NL];
    int bshift[NL], slips[NL], steps[NL], fe_mode[NL], cnt_b[NL], rst_run[NL];
    int cyc, last_slip[NL];
    logic [W-1:0] prev_pres[NL], prev_tx[NL];
    logic [PW-1:0] prev_txpos[NL];
    logic prev_link[NL], prev_en[NL];
    logic [NL-1:0] en_req;
    bit inj_align[NL], inj_req[NL];
    bit arm_same, same_done;
    logic exp_irq;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int k);
        if (k == 0) return x;
        return (x << k) | (x >> (W - k));
    endfunction

    function automatic int pnext(input int p);
        return (p == W - 1) ? 0 : p + 1;
    endfunction

    // far-end model, input driver and per-cycle monitor
    always @(negedge clk) begin
        lane_en = en_req;
        if (!mon_on) begin
            for (int l = 0; l < NL; l++) rx_word[l*W +: W] = P_IDLE;
        end else begin
            cyc++;
            chk(irq == exp_irq, "R11 irq", irq, exp_irq);
            for (int l = 0; l < NL; l++) begin
                logic [W-1:0] tw, out;
                logic lu, sl, exp_lu;
                int rp, tp, fe_old;
                tw = tx_word[l*W +: W];
                lu = link_up[l];
                sl = rx_slip[l];
                rp = int'(rx_pos[l*PW +: PW]);
                tp = int'(tx_pos[l*PW +: PW]);
                exp_lu = prev_en[l] && ((prev_tx[l] == P_ALIGN && prev_pres[l] == P_IDLE) ||
                         (prev_link[l] && prev_pres[l] != P_ALIGN && prev_pres[l] != P_REQ));
                chk(lu == exp_lu, "R8 R9 link_up", lu, exp_lu);
                if (prev_link[l] && !lu && prev_en[l])
                    chk(tw == P_REQ, "R9 request after drop", tw, P_REQ);
                if (!prev_en[l])
                    chk(!lu && !sl && tw == P_REQ, "R10 disabled lane", {lu, sl}, 0);
                if (sl) begin
                    chk(prev_pres[l] != P_ALIGN, "R3 slip on align", prev_pres[l], 0);
                    if (last_slip[l] >= 0)
                        chk(cyc - last_slip[l] >= SW + 1, "R3 slip gap", cyc - last_slip[l], SW + 1);
                    last_slip[l] = cyc;
                    bshift[l] = pnext(bshift[l]);
                    slips[l]++;
                end
                chk(rp == bshift[l], "R4 rx_pos", rp, bshift[l]);
                if (tw == P_REQ) rst_run[l]++;
                if (tw == P_ALIGN && prev_tx[l] == P_REQ) begin
                    chk(prev_pres[l] == P_ALIGN, "R5 align start", prev_pres[l], P_ALIGN);
                    chk(rst_run[l] >= RLEN, "R2 request length", rst_run[l], RLEN);
                end
                if (tw != P_REQ) rst_run[l] = 0;
                if (tp != int'(prev_txpos[l])) begin
                    chk(cnt_b[l] == RUN, "R6 run length", cnt_b[l], RUN);
                    chk(tp == pnext(int'(prev_txpos[l])), "R7 tx step", tp, pnext(int'(prev_txpos[l])));
                    chk(prev_tx[l] == P_ALIGN, "R7 tx phase", prev_tx[l], P_ALIGN);
                    cnt_b[l] = 0;
                    steps[l]++;
                end
                fe_old = fe_mode[l];
                if (tw == P_REQ) fe_mode[l] = 1;
                else if (fe_mode[l] == 1 && tw == P_ALIGN && tp == tgt[l] && steps[l] >= tx_gate[l])
                    fe_mode[l] = 2;
                out = (fe_mode[l] == 1 && slips[l] >= rx_gate[l]) ? P_ALIGN : P_IDLE;
                if (fe_mode[l] == 1 && tw == P_ALIGN && ($urandom % 256) == 0) out = P_ALIGN ^ 34'h1;
                if (inj_align[l]) begin out = P_ALIGN; inj_align[l] = 0; end
                if (inj_req[l])   begin out = P_REQ;   inj_req[l] = 0; end
                if (tw == P_ALIGN && out == P_ALIGN) cnt_b[l]++;
                else cnt_b[l] = 0;
                if (arm_same && l == 2 && fe_old == 1 && fe_mode[l] == 2 && link_up[0] && link_up[1]) begin
                    en_req[3]  = 1'b0;
                    lane_en[3] = 1'b0;
                    arm_same   = 0;
                    same_done  = 1;
                end
                prev_pres[l] = rotl(out, (true_off[l] + bshift[l]) % W);
                rx_word[l*W +: W] = prev_pres[l];
                prev_tx[l]    = tw;
                prev_link[l]  = lu;
                prev_txpos[l] = PW'(tp);
            end
            for (int l = 0; l < NL; l++) prev_en[l] = lane_en[l];
            exp_irq = (|lane_en) && (&(link_up | ~lane_en));
        end
    end

    task automatic wait_up(input int l, input int lim, input string req);
        int n = 0;
        while (!link_up[l] && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk(link_up[l] == 1'b1, req, link_up[l], 1);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int l = 0; l < NL; l++) begin
            bshift[l] = 0; slips[l] = 0; steps[l] = 0; fe_mode[l] = 0; cnt_b[l] = 0;
            rst_run[l] = 0; last_slip[l] = -1; prev_pres[l] = P_IDLE; prev_tx[l] = P_REQ;
            prev_txpos[l] = '0; prev_link[l] = 0; prev_en[l] = 1; inj_align[l] = 0; inj_req[l] = 0;
            rx_gate[l] = 0; tx_gate[l] = 0;
        end
        true_off[0] = $urandom % W;  tgt[0] = $urandom % 24;
        true_off[1] = 5;             tgt[1] = 10; rx_gate[1] = 40;   // receive wrap
        true_off[2] = 0;             tgt[2] = 20; tx_gate[2] = 34;   // no slips, transmit wrap
        true_off[3] = $urandom % W;  tgt[3] = $urandom % W; tx_gate[3] = 1000000;
        cyc = 0; exp_irq = 0; arm_same = 1; same_done = 0;
        en_req = '1;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        for (int l = 0; l < NL; l++) begin
            chk(tx_word[l*W +: W] == P_REQ, "R1 tx_word", tx_word[l*W +: W], P_REQ);
            chk(rx_pos[l*PW +: PW] == 0 && tx_pos[l*PW +: PW] == 0, "R1 positions",
                {rx_pos[l*PW +: PW], tx_pos[l*PW +: PW]}, 0);
        end
        chk(link_up == '0 && rx_slip == '0 && irq == 1'b0, "R1 flags", {link_up, rx_slip, irq}, 0);
        rst_n  = 1'b1;
        mon_on = 1;

        wait_up(0, 20000, "R8 lane0");
        wait_up(1, 20000, "R4 R8 lane1 after wrap");
        wait_up(2, 20000, "R7 R8 lane2 after wrap");
        chk(slips[1] > W, "R4 receive wrap exercised", slips[1], W);
        chk(steps[2] > W, "R7 transmit wrap exercised", steps[2], W);
        chk(slips[2] == 0, "R3 no slip when aligned", slips[2], 0);
        @(posedge clk);
        if (!same_done) en_req[3] = 1'b0;
        arm_same = 0;
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R11 ready with lane3 disabled", irq, 1);
        chk(link_up[3] == 1'b0, "R10 disabled lane down", link_up[3], 0);

        @(posedge clk);
        tx_gate[3] = 0;
        en_req[3]  = 1'b1;
        wait_up(3, 20000, "R8 lane3");
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R11 all lanes", irq, 1);

        @(posedge clk) inj_align[0] = 1;
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R11 drop on reinit", irq, 0);
        wait_up(0, 5000, "R9 relink after align");
        chk(int'(tx_pos[0*PW +: PW]) == tgt[0], "R9 tx_pos retained", tx_pos[0*PW +: PW], tgt[0]);
        @(posedge clk) inj_req[1] = 1;
        repeat (3) @(negedge clk);
        wait_up(1, 5000, "R9 relink after request");

        for (int k = 0; k < 8; k++) begin
            int l, m;
            l = $urandom % NL;
            m = $urandom % 3;
            @(posedge clk);
            case (m)
                0: inj_align[l] = 1;
                1: inj_req[l] = 1;
                default: begin
                    en_req[l] = 1'b0;
                    repeat (1 + $urandom % 20) @(posedge clk);
                    en_req[l] = 1'b1;
                end
            endcase
            repeat (4) @(negedge clk);
            wait_up(l, 5000, "R9 R10 random relink");
        end

        repeat (4) @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(link_up[l] == 1'b1, "R8 final link", link_up[l], 1);
            chk(int'(tx_pos[l*PW +: PW]) == tgt[l], "R7 final tx_pos", tx_pos[l*PW +: PW], tgt[l]);
            chk((true_off[l] + int'(rx_pos[l*PW +: PW])) % W == 0, "R4 final rx_pos",
                rx_pos[l*PW +: PW], (W - true_off[l]) % W);
        end
        chk(irq == 1'b1, "R11 final", irq, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule